// File: doc/BRIEF.md
# Device Power State Controller

This block follows the power management state of a network interface on a PCIe-style link and drives the active-low wake request line toward the host. A power-good input, software writes of a requested device state, a memory-access enable and a set of wake-related controls decide the state. The state is reported as one of four codes. Dr covers loss of power, including D3cold. D0 is split into an uninitialized sub-state (D0u) and an active sub-state (D0a). D3 is the low-power state that software selects.

A sticky PME status flag records wake events. Software clears it by writing 1. The wake line goes low when that flag is set and wake is allowed. Wake can be allowed by PME enable, or by an APM-wake enable that works even while PME enable is clear. A power-management enable taken from initialization can turn off software entry into D3. The state and status outputs stay readable whatever that enable is set to.

Top module: `pm_state_ctrl`

## Requirements
- R1: The state code is Dr (2'b00) during reset. After any clock edge at which powerGood is sampled low, the state is Dr, whatever the previous state was.
- R2: The state leaves Dr for D0u (2'b01) only after powerGood has been sampled high at PG_STABLE (default 2) consecutive edges. A single high sample followed by a low sample leaves it in Dr.
- R3: With no accepted D3 request, D0u moves to D0a (2'b10) at the edge where memEnable is high, and D0a returns to D0u at the edge where memEnable is low.
- R4: A write with reqWrite high and reqState 2'b11 moves D0u or D0a to D3 (2'b11). A write with reqState 2'b00 in D3 moves to D0u. Every other write code or state combination leaves the state unchanged, and memEnable has no effect in D3.
- R5: With apmWakeEn low and the PM functions enabled, a wakeEvent in D3 sets pmeStatus at the next edge. If pmeEnable is high, wakeN goes low one edge after that.
- R6: pmeStatus stays set until pmeStatusClr is pulsed, and it is 0 after that edge. A new wake event in the same cycle as the clear takes priority over it. wakeN returns high one edge after pmeStatus clears.
- R7: With apmWakeEn low, a wakeEvent in D0u or D0a does not set pmeStatus.
- R8: With apmWakeEn high, a wakeEvent in D0u, D0a or D3 sets pmeStatus, and wakeN goes low one edge later even when pmeEnable is 0.
- R9: In Dr, wakeN is high, pmeStatus is 0, and wake events have no effect.
- R10: When pmEnableInit is 0, D3 write requests are ignored, while pmState and pmeStatus still report the current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supply good indication |
| pmEnableInit | input | 1 | PM functions enabled, from initialization |
| reqWrite | input | 1 | Strobe for a software state request |
| reqState | input | 2 | Requested state: 2'b00 = D0, 2'b11 = D3 |
| memEnable | input | 1 | Memory-access enable from software |
| pmeEnable | input | 1 | PME enable bit |
| pmeStatusClr | input | 1 | Write-1-to-clear pulse for PME status |
| apmWakeEn | input | 1 | APM wake enable |
| wakeEvent | input | 1 | One-cycle wake event pulse |
| pmState | output | 2 | Current state: 00 Dr, 01 D0u, 10 D0a, 11 D3 |
| pmeStatus | output | 1 | Sticky PME status |
| wakeN | output | 1 | Active-low wake request |

## Verification
On every cycle, the assertions check the following. Loss of power-good forces Dr. D3 is entered only through an accepted request. Dr exit waits for the stability strobe. PME status stays set until cleared. The wake line asserts only when status and an enable held in the cycle before, and it stays high in Dr. The bench scenarios cover the rest. A sweep of every request code against every reachable start state shows which writes are ignored. Directed sequences show the short power-good glitch, the one-edge lags from wake event to status and from status to wake line, set priority over clear, the APM path with PME enable clear, and the effect of the initialization disable.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    ST_DR  = 2'b00,
    ST_D0U = 2'b01,
    ST_D0A = 2'b10,
    ST_D3  = 2'b11
  } pmState_t;

  localparam logic [1:0] REQ_D0 = 2'b00;
  localparam logic [1:0] REQ_D3 = 2'b11;

  typedef struct packed {
    logic setStatus;
    logic clrStatus;
    logic wakeArm;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       pgStable,
  input  logic       pmEnableInit,
  input  logic       reqWrite,
  input  logic [1:0] reqState,
  input  logic       memEnable,
  input  logic       pmeStatusClr,
  input  logic       apmWakeEn,
  input  logic       wakeEvent,
  output pmState_t   state,
  output pmStrobe_t  strobes
);
  pmState_t nextState;
  logic     d3Req;
  logic     d0Req;

  assign d3Req = reqWrite && (reqState == REQ_D3) && pmEnableInit;
  assign d0Req = reqWrite && (reqState == REQ_D0);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_DR:  if (pgStable) nextState = ST_D0U;
      ST_D0U: begin
        if (d3Req)          nextState = ST_D3;
        else if (memEnable) nextState = ST_D0A;
      end
      ST_D0A: begin
        if (d3Req)           nextState = ST_D3;
        else if (!memEnable) nextState = ST_D0U;
      end
      ST_D3:  if (d0Req) nextState = ST_D0U;
      default: nextState = ST_DR;
    endcase
    if (!powerGood) nextState = ST_DR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DR;
    else       state <= nextState;
  end

  always_comb begin
    strobes.wakeArm   = (state != ST_DR) && powerGood;
    strobes.setStatus = wakeEvent && strobes.wakeArm &&
                        (apmWakeEn || ((state == ST_D3) && pmEnableInit));
    strobes.clrStatus = (state == ST_DR) || !powerGood || pmeStatusClr;
  end

  AST_PG_LOSS_DR: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> state == ST_DR); // R1

  AST_DR_EXIT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_D0U && $past(state) == ST_DR) |-> $past(pgStable)); // R2

  AST_D3_ENTRY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_D3 && $past(state) != ST_D3) |->
      $past(reqWrite && reqState == REQ_D3 && pmEnableInit)); // R4
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int PG_STABLE = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerGood,
  input  logic      pmeEnable,
  input  logic      apmWakeEn,
  input  pmStrobe_t strobes,
  output logic      pgStable,
  output logic      pmeStatus,
  output logic      wakeReq
);
  localparam int CNT_W = $clog2(PG_STABLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PG_STABLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PG_STABLE - 1);

  logic [CNT_W-1:0] goodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  goodCnt <= '0;
    else if (!powerGood)        goodCnt <= '0;
    else if (goodCnt != CNT_MAX) goodCnt <= goodCnt + 1'b1;
  end

  assign pgStable = powerGood && (goodCnt >= CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pmeStatus <= 1'b0;
    else if (strobes.setStatus) pmeStatus <= 1'b1;
    else if (strobes.clrStatus) pmeStatus <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeReq <= 1'b0;
    else       wakeReq <= pmeStatus && (pmeEnable || apmWakeEn) && strobes.wakeArm;
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pmeStatus && !strobes.clrStatus) |=> pmeStatus); // R6

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(pmeStatus && (pmeEnable || apmWakeEn))); // R5
endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter int PG_STABLE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       pmEnableInit,
  input  logic       reqWrite,
  input  logic [1:0] reqState,
  input  logic       memEnable,
  input  logic       pmeEnable,
  input  logic       pmeStatusClr,
  input  logic       apmWakeEn,
  input  logic       wakeEvent,
  output logic [1:0] pmState,
  output logic       pmeStatus,
  output logic       wakeN
);
  pmState_t  state;
  pmStrobe_t strobes;
  logic      pgStable;
  logic      wakeReq;

  pm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .pgStable(pgStable),
    .pmEnableInit(pmEnableInit), .reqWrite(reqWrite), .reqState(reqState),
    .memEnable(memEnable), .pmeStatusClr(pmeStatusClr), .apmWakeEn(apmWakeEn),
    .wakeEvent(wakeEvent), .state(state), .strobes(strobes)
  );

  pm_datapath #(.PG_STABLE(PG_STABLE)) i_datapath (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .pmeEnable(pmeEnable),
    .apmWakeEn(apmWakeEn), .strobes(strobes), .pgStable(pgStable),
    .pmeStatus(pmeStatus), .wakeReq(wakeReq)
  );

  assign pmState = state;
  assign wakeN   = !wakeReq;

  AST_DR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == ST_DR) |-> (wakeN && !pmeStatus)); // R9
endmodule

// File: tb/test_pm_state_ctrl.sv
`timescale 1ns/1ps
module test_pm_state_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0, pmEnableInit = 1'b1, reqWrite = 1'b0;
  logic [1:0] reqState = 2'b00;
  logic memEnable = 1'b0, pmeEnable = 1'b0, pmeStatusClr = 1'b0;
  logic apmWakeEn = 1'b0, wakeEvent = 1'b0;
  logic [1:0] pmState;
  logic pmeStatus, wakeN;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] DR = 2'b00, D0U = 2'b01, D0A = 2'b10, D3 = 2'b11;

  always #2.5 clk = ~clk;

  pm_state_ctrl i_pm_state_ctrl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .pmEnableInit(pmEnableInit),
    .reqWrite(reqWrite), .reqState(reqState), .memEnable(memEnable),
    .pmeEnable(pmeEnable), .pmeStatusClr(pmeStatusClr), .apmWakeEn(apmWakeEn),
    .wakeEvent(wakeEvent), .pmState(pmState), .pmeStatus(pmeStatus), .wakeN(wakeN)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic goDr();
    powerGood = 1'b0; memEnable = 1'b0; reqWrite = 1'b0;
    tick();
  endtask

  task automatic goState(input logic [1:0] s);
    goDr();
    powerGood = 1'b1;
    tick(); tick();
    if (s == D0A) begin memEnable = 1'b1; tick(); end
    if (s == D3) begin
      reqWrite = 1'b1; reqState = D3; tick(); reqWrite = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(pmState, DR, "R1 reset state");
    chk(wakeN, 1, "R9 reset wakeN");
    chk(pmeStatus, 0, "R9 reset status");
    rstN = 1'b1;
    tick();

    // R2 glitch then stable
    powerGood = 1'b1; tick();
    chk(pmState, DR, "R2 after one good sample");
    powerGood = 1'b0; tick();
    powerGood = 1'b1; tick();
    chk(pmState, DR, "R2 glitch restarts count");
    tick();
    chk(pmState, D0U, "R2 exit to D0u");

    // R3
    memEnable = 1'b1; tick();
    chk(pmState, D0A, "R3 D0u to D0a");
    memEnable = 1'b0; tick();
    chk(pmState, D0U, "R3 D0a to D0u");

    // R4 sweep: start state x request code
    for (int s = 1; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] expS;
        goState(2'(s));
        chk(pmState, s, "R4 setup state");
        if (s == D3) memEnable = 1'b1;
        reqWrite = 1'b1; reqState = 2'(c);
        tick();
        reqWrite = 1'b0;
        if (s != D3 && c == 3) expS = D3;
        else if (s == D3 && c == 0) expS = D0U;
        else expS = 2'(s);
        chk(pmState, expS, "R4 request sweep");
        memEnable = 1'b0;
      end
    end

    // R5 PME wake in D3
    goState(D3);
    pmeEnable = 1'b1; wakeEvent = 1'b1; tick(); wakeEvent = 1'b0;
    chk(pmeStatus, 1, "R5 status set in D3");
    chk(wakeN, 1, "R5 wakeN lags status");
    tick();
    chk(wakeN, 0, "R5 wakeN asserted");
    tick();
    chk(pmeStatus, 1, "R6 status sticky");
    // R6 set wins over clear
    pmeStatusClr = 1'b1; wakeEvent = 1'b1; tick();
    wakeEvent = 1'b0;
    chk(pmeStatus, 1, "R6 set beats clear");
    tick(); pmeStatusClr = 1'b0;
    chk(pmeStatus, 0, "R6 cleared");
    chk(wakeN, 0, "R6 wakeN one edge late");
    tick();
    chk(wakeN, 1, "R6 wakeN released");

    // R5 without PME enable
    pmeEnable = 1'b0; wakeEvent = 1'b1; tick(); wakeEvent = 1'b0;
    chk(pmeStatus, 1, "R5 status set pme off");
    tick();
    chk(wakeN, 1, "R5 no wake with pme off");
    pmeStatusClr = 1'b1; tick(); pmeStatusClr = 1'b0;

    // R7 D0 states, apm off
    for (int s = 1; s < 3; s++) begin
      goState(2'(s));
      pmeEnable = 1'b1; wakeEvent = 1'b1; tick(); wakeEvent = 1'b0;
      chk(pmeStatus, 0, "R7 no status in D0");
      tick();
      chk(wakeN, 1, "R7 no wake in D0");
    end

    // R8 APM wake in every non-Dr state with pme off
    for (int s = 1; s < 4; s++) begin
      goState(2'(s));
      pmeEnable = 1'b0; apmWakeEn = 1'b1;
      wakeEvent = 1'b1; tick(); wakeEvent = 1'b0;
      chk(pmeStatus, 1, "R8 apm sets status");
      tick();
      chk(wakeN, 0, "R8 apm asserts wake");
      // R1/R9 power loss
      powerGood = 1'b0; tick();
      chk(pmState, DR, "R1 power loss to Dr");
      chk(wakeN, 1, "R9 wakeN high in Dr");
      chk(pmeStatus, 0, "R9 status cleared in Dr");
      wakeEvent = 1'b1; tick(); wakeEvent = 1'b0;
      chk(pmeStatus, 0, "R9 wake ignored in Dr");
      apmWakeEn = 1'b0;
    end

    // R10 PM disabled
    pmEnableInit = 1'b0;
    goState(D0A);
    reqWrite = 1'b1; reqState = D3; tick(); reqWrite = 1'b0;
    chk(pmState, D0A, "R10 D3 ignored when disabled");
    memEnable = 1'b0; tick();
    chk(pmState, D0U, "R10 state still reported");
    pmEnableInit = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule